// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one serial flash transaction each time software starts it through a small 32-bit register bus. Software first loads a command word, which packs an opcode and a 24-bit address, and optionally a payload word. It then writes the control register with a transmit byte count, a receive byte count, a serial clock rate and the start bit. The engine selects the flash and shifts out the opcode, the address bytes and up to four payload bytes, as many as the transmit count asks for. It then clocks in up to four response bytes and drops them into the payload word.

Busy stays set from the start until chip select has been released and one idle serial clock period has passed. Software therefore polls busy and reads the response afterwards. While busy is set the registers cannot be written, so the bytes being shifted out cannot change under the transfer.

Top module: `sfc_engine`

## Requirements
- R1: The registers sit at byte offsets 0x0 (control), 0x4 (command word) and 0x8 (payload word). Control reads back the transmit count in [3:0], the receive count in [7:4], the clock select in [25:24] and busy in [16]. Bit 8 (start) and all other bits read 0. The count and clock fields keep their written values across reads.
- R2: A control write with bit 8 set and a transmit count other than 0, made while busy is clear, sets busy and drives chip select low in the next cycle.
- R3: A start with a transmit count of 0 starts nothing: busy stays 0 and chip select stays high. The written fields are still stored.
- R4: The first byte sent is command word bits [7:0]. The next bytes are [31:24], then [23:16], then [15:8], as far as the transmit count reaches.
- R5: Transmit bytes 5 to 8 are payload bits [7:0], [15:8], [23:16] and [31:24], in that order. A transmit count above 8 behaves as 8.
- R6: Once the transmit bytes are sent, the engine receives as many bytes as the receive count gives, at most 4 (a larger count behaves as 4). Received byte i is written to payload bits [8i+7:8i]. Payload lanes above the receive count keep their values.
- R7: The serial interface uses mode 0. The serial clock is low whenever chip select is high. MOSI changes only while the serial clock is low. Every byte is sent and received MSB first. MISO is sampled on the rising serial clock edge.
- R8: One serial clock half period lasts 2^S system clocks, where S is the clock select. With B bytes in total (transmit plus receive, after clamping), chip select stays low for exactly 16*B*2^S cycles and gives exactly 8*B rising serial clock edges.
- R9: After chip select rises, busy stays set for one more serial clock period (2*2^S cycles). Busy therefore lasts (16*B+2)*2^S cycles in total. Chip select is never low while busy is clear.
- R10: While busy is set, every bus write is ignored: a second start, new control fields, and writes to the command or payload word.
- R11: After reset all three registers read 0, chip select is high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A start write taken at one clock edge raises busy and lowers chip select in the cycle right after that edge. With S the clock select and B the total byte count, chip select then stays low for 16*B*2^S cycles and busy for (16*B+2)*2^S cycles. Each received byte is in the payload word before busy falls. The bench model holds one countdown per transaction, which it loads from the accepted control word at the same edge as the design. It compares busy and chip select one nanosecond after every rising edge. The checks on the byte stream, the payload lanes and the control readback run only after the model's countdown has reached zero.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int REG_W        = 32;
    localparam int MAX_TX_BYTES = 8;
    localparam int MAX_RX_BYTES = 4;
    localparam int MAX_BITS     = (MAX_TX_BYTES + MAX_RX_BYTES) * 8;
    localparam int BIT_W        = $clog2(MAX_BITS + 1);

    localparam int OFF_CTRL = 0;
    localparam int OFF_CMD  = 4;
    localparam int OFF_DATA = 8;

    localparam int CTRL_GO_BIT = 8;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic [3:0] rx_cnt;
        logic [3:0] tx_cnt;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_e;

    function automatic logic [3:0] clamp_tx(input logic [3:0] n);
        return (n > 4'(MAX_TX_BYTES)) ? 4'(MAX_TX_BYTES) : n;
    endfunction

    function automatic logic [3:0] clamp_rx(input logic [3:0] n);
        return (n > 4'(MAX_RX_BYTES)) ? 4'(MAX_RX_BYTES) : n;
    endfunction

    // Byte order on the wire: opcode, address high..low, payload lanes low..high
    function automatic logic [7:0] pick_tx_byte(input logic [REG_W-1:0] cmd,
                                                input logic [REG_W-1:0] pay,
                                                input logic [2:0]       idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = cmd[7:0];
            3'd1:    b = cmd[31:24];
            3'd2:    b = cmd[23:16];
            3'd3:    b = cmd[15:8];
            default: b = pay[{idx[1:0], 3'b000} +: 8];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sfc_clkdiv.sv
module sfc_clkdiv
    import sfc_pkg::*;
#(
    parameter int HALF_BASE = 1,
    localparam int DIV_W    = $clog2(HALF_BASE * 8 + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick,
    output logic       sclk_int
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_m1;
    logic             sclk_q;

    assign half_m1  = (DIV_W'(HALF_BASE) << sel) - DIV_W'(1);
    assign tick     = run && (cnt_q == half_m1);
    assign sclk_int = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sfc_regs.sv
module sfc_regs
    import sfc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              rx_we,
    input  logic [1:0]        rx_lane,
    input  logic [7:0]        rx_byte,
    output ctrl_t             ctrl,
    output logic [REG_W-1:0]  cmd_word,
    output logic [REG_W-1:0]  pay_word,
    output logic              start_go
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);

    ctrl_t            ctrl_q;
    logic [REG_W-1:0] cmd_q;
    logic [REG_W-1:0] pay_q;
    logic             wr_ok;

    assign wr_ok    = bus_wr && !busy;
    assign start_go = wr_ok && (bus_addr == A_CTRL) &&
                      bus_wdata[CTRL_GO_BIT] && (bus_wdata[3:0] != 4'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmd_q  <= '0;
            pay_q  <= '0;
        end else begin
            if (wr_ok) begin
                case (bus_addr)
                    A_CTRL: ctrl_q <= '{clk_sel: bus_wdata[25:24],
                                        rx_cnt:  bus_wdata[7:4],
                                        tx_cnt:  bus_wdata[3:0]};
                    A_CMD:  cmd_q  <= bus_wdata;
                    A_DATA: pay_q  <= bus_wdata;
                    default: ;
                endcase
            end
            if (rx_we) begin
                pay_q[{rx_lane, 3'b000} +: 8] <= rx_byte;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = {6'b0, ctrl_q.clk_sel, 7'b0, busy, 8'b0,
                                  ctrl_q.rx_cnt, ctrl_q.tx_cnt};
            A_CMD:   bus_rdata = cmd_q;
            A_DATA:  bus_rdata = pay_q;
            default: bus_rdata = '0;
        endcase
    end

    assign ctrl     = ctrl_q;
    assign cmd_word = cmd_q;
    assign pay_word = pay_q;
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
    import sfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_go,
    input  ctrl_t            ctrl,
    input  logic [REG_W-1:0] cmd_word,
    input  logic [REG_W-1:0] pay_word,
    input  logic             tick,
    input  logic             sclk_int,
    input  logic             miso,
    output logic             busy,
    output logic             selected,
    output logic             mosi,
    output logic             rx_we,
    output logic [1:0]       rx_lane,
    output logic [7:0]       rx_byte
);
    seq_state_e       state_q;
    logic [BIT_W-1:0] bit_q;
    logic [6:0]       rxsh_q;
    logic             gap_half_q;
    logic [BIT_W-1:0] tx_bits;
    logic [BIT_W-1:0] all_bits;
    logic [BIT_W-1:0] rx_off;
    logic [7:0]       cur_byte;

    assign tx_bits  = BIT_W'(clamp_tx(ctrl.tx_cnt)) << 3;
    assign all_bits = (BIT_W'(clamp_tx(ctrl.tx_cnt)) + BIT_W'(clamp_rx(ctrl.rx_cnt))) << 3;
    assign rx_off   = bit_q - tx_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            bit_q      <= '0;
            rxsh_q     <= '0;
            gap_half_q <= 1'b0;
            rx_we      <= 1'b0;
            rx_lane    <= '0;
            rx_byte    <= '0;
        end else begin
            rx_we <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_go) begin
                        state_q    <= ST_SHIFT;
                        bit_q      <= '0;
                        gap_half_q <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_int) begin
                            // rising serial edge: sample
                            rxsh_q <= {rxsh_q[5:0], miso};
                            if ((bit_q >= tx_bits) && (bit_q[2:0] == 3'd7)) begin
                                rx_we   <= 1'b1;
                                rx_lane <= 2'(rx_off >> 3);
                                rx_byte <= {rxsh_q, miso};
                            end
                        end else if (bit_q == all_bits - BIT_W'(1)) begin
                            state_q <= ST_GAP;
                        end else begin
                            bit_q <= bit_q + BIT_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half_q) state_q <= ST_IDLE;
                        gap_half_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cur_byte = pick_tx_byte(cmd_word, pay_word, 3'(bit_q >> 3));
    assign mosi     = (state_q == ST_SHIFT) && (bit_q < tx_bits) && cur_byte[~bit_q[2:0]];
    assign busy     = (state_q != ST_IDLE);
    assign selected = (state_q == ST_SHIFT);
endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
    import sfc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int HALF_BASE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    ctrl_t            ctrl;
    logic [REG_W-1:0] cmd_word;
    logic [REG_W-1:0] pay_word;
    logic             start_go;
    logic             busy;
    logic             selected;
    logic             tick;
    logic             sclk_int;
    logic             rx_we;
    logic [1:0]       rx_lane;
    logic [7:0]       rx_byte;

    sfc_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .busy(busy),
        .rx_we(rx_we), .rx_lane(rx_lane), .rx_byte(rx_byte),
        .ctrl(ctrl), .cmd_word(cmd_word), .pay_word(pay_word),
        .start_go(start_go)
    );

    sfc_clkdiv #(.HALF_BASE(HALF_BASE)) div_i (
        .clk(clk), .rst(rst), .run(busy), .sel(ctrl.clk_sel),
        .tick(tick), .sclk_int(sclk_int)
    );

    sfc_seq seq_i (
        .clk(clk), .rst(rst), .start_go(start_go), .ctrl(ctrl),
        .cmd_word(cmd_word), .pay_word(pay_word),
        .tick(tick), .sclk_int(sclk_int), .miso(spi_miso),
        .busy(busy), .selected(selected), .mosi(spi_mosi),
        .rx_we(rx_we), .rx_lane(rx_lane), .rx_byte(rx_byte)
    );

    assign spi_sclk = sclk_int && selected;
    assign spi_cs_n = !selected;
endmodule

// File: rtl/sfc_engine_chk.sv
module sfc_engine_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              spi_cs_n,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == '0);

    AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk); // R7

    AST_MOSI_HELD_SCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R7

    AST_START_SELECTS: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctrl_wr && bus_wdata[8] && (bus_wdata[3:0] != 4'd0))
        |=> (busy && !spi_cs_n)); // R2

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctrl_wr && bus_wdata[8])); // R2

    AST_ZERO_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctrl_wr && (bus_wdata[3:0] == 4'd0)) |=> !busy); // R3

    AST_DESELECT_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (spi_cs_n && $past(spi_cs_n))); // R9

    AST_SELECT_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> busy); // R9
endmodule

bind sfc_engine sfc_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/sfc_engine_tb_top.sv
`timescale 1ns/1ps
module sfc_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        miso_r;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sfc_engine dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(miso_r)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- flash stub ----------------
    int         sbit = 0;
    int         cur_tx = 0, cur_rx = 0;
    logic [7:0] cap  [16];
    logic [7:0] resp [4];

    always @(posedge spi_sclk) begin
        if (sbit < 128) cap[sbit / 8] = {cap[sbit / 8][6:0], spi_mosi};
        sbit++;
    end

    always @* begin
        miso_r = 1'b0;
        if (!spi_cs_n && sbit >= cur_tx * 8 && sbit < (cur_tx + cur_rx) * 8)
            miso_r = resp[(sbit - cur_tx * 8) / 8][7 - (sbit % 8)];
    end

    // ---------------- per-cycle model ----------------
    int rem = 0;
    int mh  = 1;

    always @(posedge clk) begin
        if (rst) begin
            rem = 0;
        end else if (rem > 0) begin
            rem--;
        end else if (bus_wr && bus_addr == 4'h0 && bus_wdata[8] && bus_wdata[3:0] != 4'd0) begin
            automatic int t = (bus_wdata[3:0] > 8) ? 8 : int'(bus_wdata[3:0]);
            automatic int r = (bus_wdata[7:4] > 4) ? 4 : int'(bus_wdata[7:4]);
            mh  = 1 << bus_wdata[25:24];
            rem = (16 * (t + r) + 2) * mh;
        end
        #1;
        if (!rst) begin
            chk("R8 chip select per cycle", {31'd0, spi_cs_n}, {31'd0, !(rem > 2 * mh)});
            if (bus_addr == 4'h0)
                chk("R9 busy per cycle", {31'd0, bus_rdata[16]}, {31'd0, rem > 0});
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = 4'h0;
    endtask

    logic [31:0] exp_cmd = 0, exp_pay = 0, exp_ctrl = 0;

    function automatic logic [7:0] wire_byte(input int i);
        if (i == 0) return exp_cmd[7:0];
        if (i < 4)  return exp_cmd[8 * (4 - i) +: 8];
        return exp_pay[8 * (i - 4) +: 8];
    endfunction

    task automatic begin_txn(input int tx, input int rx, input int sel);
        cur_tx = (tx > 8) ? 8 : tx;
        cur_rx = (rx > 4) ? 4 : rx;
        sbit = 0;
        for (int i = 0; i < 16; i++) cap[i] = 8'h00;
        exp_ctrl = {6'd0, 2'(sel), 16'd0, 4'(rx), 4'(tx)};
        wr(4'h0, exp_ctrl | 32'h100);
    endtask

    task automatic end_txn(input string tag);
        logic [31:0] v;
        while (rem != 0) @(negedge clk);
        @(negedge clk);
        chk({tag, " R8 sclk edges"}, sbit, (cur_tx + cur_rx) * 8);
        for (int i = 0; i < cur_tx; i++)
            chk({tag, " R4 R5 wire byte"}, {24'd0, cap[i]}, {24'd0, wire_byte(i)});
        for (int i = 0; i < cur_rx; i++) exp_pay[8 * i +: 8] = resp[i];
        rd(4'h8, v);
        chk({tag, " R6 payload after receive"}, v, exp_pay);
        rd(4'h0, v);
        chk({tag, " R1 control readback"}, v, exp_ctrl);
        rd(4'h4, v);
        chk({tag, " R1 command readback"}, v, exp_cmd);
    endtask

    task automatic load(input logic [31:0] c, input logic [31:0] p);
        exp_cmd = c; exp_pay = p;
        wr(4'h4, c);
        wr(4'h8, p);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd(4'h0, v); chk("R11 control after reset", v, 32'd0);
        rd(4'h4, v); chk("R11 command after reset", v, 32'd0);
        rd(4'h8, v); chk("R11 payload after reset", v, 32'd0);
        chk("R11 cs_n after reset", {31'd0, spi_cs_n}, 32'd1);
        chk("R11 sclk after reset", {31'd0, spi_sclk}, 32'd0);

        // signature style: 4 out, 1 in, fastest clock
        load(32'h000000AB, 32'hDEADBEEF);
        resp[0] = 8'h17; resp[1] = 8'h00; resp[2] = 8'h00; resp[3] = 8'h00;
        begin_txn(4, 1, 0); end_txn("sig");

        // program style: 2 payload bytes
        load(32'h12345602, 32'h44332211);
        begin_txn(6, 0, 1); end_txn("prog");

        // full frame
        load(32'hA5C3E103, 32'h0F1E2D3C);
        resp[0] = 8'hA1; resp[1] = 8'hB2; resp[2] = 8'hC3; resp[3] = 8'hD4;
        begin_txn(8, 4, 2); end_txn("full");

        // counts above limits clamp (R5 R6)
        load(32'h8001FF0B, 32'h99887766);
        resp[0] = 8'h5A; resp[1] = 8'h3C; resp[2] = 8'hC3; resp[3] = 8'h81;
        begin_txn(15, 9, 3); end_txn("clamp");

        // opcode then two received bytes, upper lanes preserved (R6)
        load(32'h00000005, 32'h55667788);
        resp[0] = 8'h02; resp[1] = 8'hE7; resp[2] = 8'h00; resp[3] = 8'h00;
        begin_txn(1, 2, 0); end_txn("status");

        // R3 zero transmit count
        exp_ctrl = {6'd0, 2'd2, 16'd0, 4'd3, 4'd0};
        wr(4'h0, exp_ctrl | 32'h100);
        repeat (20) begin
            @(negedge clk);
            chk("R3 cs_n stays high", {31'd0, spi_cs_n}, 32'd1);
        end
        rd(4'h0, v); chk("R3 R1 fields stored, no busy", v, exp_ctrl);
        rd(4'h8, v); chk("R3 payload untouched", v, exp_pay);

        // R10 writes while busy are ignored
        load(32'h00FFEE9F, 32'h10203040);
        resp[0] = 8'h6B; resp[1] = 8'h00; resp[2] = 8'h00; resp[3] = 8'h00;
        begin_txn(4, 1, 1);
        repeat (3) @(negedge clk);
        wr(4'h0, 32'h03000108);
        wr(4'h8, 32'hCAFEF00D);
        wr(4'h4, 32'h11111111);
        rd(4'h0, v); chk("R10 control unchanged while busy", v, exp_ctrl | 32'h0001_0000);
        end_txn("busywr R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule